// File: doc/BRIEF.md
# Configurable Line Code Encoder

This block converts a serial NRZ data stream into a line-coded chip stream for a transmitter running in synchronous mode. Every data bit is split into two half-bit chips. The boundaries between chips come from an externally generated bit clock. A falling edge of that clock starts a bit and latches its data. The following rising edge marks the middle of the bit. A 3-bit code selector picks one of four line codes: Manchester, differential Manchester, bi-phase space or bi-phase mark.

A telegram begins when `tx_en` rises. At that edge the block captures its configuration and reloads a counter. The counter sets how many leading bits of the telegram are sent as plain NRZ before coding starts. The coded stream can be inverted. An internal 9-bit pseudo-random generator, using the polynomial x^9 + x^5 + 1 and a loadable seed, can replace the external data input.

The control state machine has four states:
- `ST_IDLE` holds the line low. Its transition `tel_start` goes to `ST_ARMED` when `tx_en` rises.
- `ST_ARMED` rests at the reference level. Its transition `bit_fall` goes to `ST_FIRST`.
- `ST_FIRST` carries the first half of a bit. Its transition `bit_rise` goes to `ST_SECOND`.
- `ST_SECOND` carries the second half. Its transition `bit_fall` returns to `ST_FIRST`.
- From any state, `tx_drop` (`tx_en` low) returns to `ST_IDLE`.

Top module: `line_code_encoder`

## Requirements
- R1: While `tx_en` is low, `line_out` is 0 from the next clock on. At the rising edge of `tx_en`, `line_out` takes the value of `invert` (the reference level) and holds it until the first bit starts.
- R2: A bit starts at the clock edge where `bit_clk` is first sampled low after being high. At that edge the data bit is latched and the first-half chip appears on `line_out`. The second-half chip appears at the edge where `bit_clk` is first sampled high. Between those edges `line_out` holds.
- R3: `code_sel` = 0 (Manchester): a 1 is sent as chips 1,0 and a 0 as chips 0,1.
- R4: `code_sel` = 1 (differential Manchester): the line always toggles mid-bit, and it toggles at the bit start only when the bit is 0.
- R5: `code_sel` = 2 (bi-phase space): the line toggles at every bit start, and it toggles again mid-bit when the bit is 0.
- R6: `code_sel` = 3 (bi-phase mark): the line toggles at every bit start, and it toggles again mid-bit when the bit is 1.
- R7: Every bit is sent unencoded as NRZ (both chips equal the bit) in any of these cases: `code_sel` is 4 to 7, `enc_en` is 0, or `sync_mode` is 0.
- R8: The first `raw_bits` bits of each telegram are sent as NRZ. The count reloads at every rise of `tx_en`. Coding then continues from the level of the last NRZ chip. The coding reference level at telegram start is 0.
- R9: When `invert` is 1 at telegram start, every chip of that telegram is complemented.
- R10: With `prbs_sel` = 1 at telegram start, `din` is ignored. Data comes from a 9-bit register s that is loaded with `prbs_seed` at telegram start. Each bit sends s[8], then s shifts to {s[7:0], s[8]^s[4]}.
- R11: A `prbs_seed` of zero is loaded as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than or equal to twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Telegram enable; rising edge starts a telegram |
| sync_mode | input | 1 | Synchronous transmit mode selected |
| enc_en | input | 1 | Line coding requested |
| code_sel | input | 3 | Line code selector |
| invert | input | 1 | Complement the chip stream |
| raw_bits | input | 8 | Number of leading NRZ bits per telegram |
| prbs_sel | input | 1 | Use the pseudo-random source instead of `din` |
| prbs_seed | input | 9 | Start value of the pseudo-random register |
| bit_clk | input | 1 | Bit clock, synchronous to `clk`; falling edge starts a bit |
| din | input | 1 | Serial NRZ data |
| line_out | output | 1 | Coded chip stream |

## Verification
The assertions check four properties on every cycle: the low idle line, holding between half-bit boundaries, the first-half chip of Manchester and of NRZ bits, and the toggle rules at bit start and mid-bit for each code. The bench's scenarios show what needs a whole telegram to observe. These are the exact chip sequences, the NRZ prefix count and its reload on a new telegram, the effect of inversion on the reference level, the pseudo-random sequence itself, and the replacement of a zero seed.

// File: rtl/lce_pkg.sv
`timescale 1ns/1ps
package lce_pkg;
    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] CODE_MANCH = 3'd0;
    localparam logic [CODE_W-1:0] CODE_DIFF  = 3'd1;
    localparam logic [CODE_W-1:0] CODE_BPS   = 3'd2;
    localparam logic [CODE_W-1:0] CODE_BPM   = 3'd3;
    localparam logic [CODE_W-1:0] CODE_LIMIT = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FIRST,
        ST_SECOND
    } lce_state_t;
endpackage

// File: rtl/lce_ctrl.sv
`timescale 1ns/1ps
module lce_ctrl
    import lce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       bit_clk,
    output lce_state_t state,
    output logic       tel_start,
    output logic       bit_start,
    output logic       mid_bit
);
    logic       tx_q;
    logic       bclk_q;
    logic       bit_fall;
    logic       bit_rise;
    lce_state_t state_nxt;

    assign bit_fall = bclk_q & ~bit_clk;
    assign bit_rise = ~bclk_q & bit_clk;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tx_q   <= 1'b0;
            bclk_q <= 1'b1;
        end else begin
            state  <= state_nxt;
            tx_q   <= tx_en;
            bclk_q <= bit_clk;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (!tx_en) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (tel_start) state_nxt = ST_ARMED;
                ST_ARMED:  if (bit_fall)  state_nxt = ST_FIRST;
                ST_FIRST:  if (bit_rise)  state_nxt = ST_SECOND;
                ST_SECOND: if (bit_fall)  state_nxt = ST_FIRST;
            endcase
        end
    end

    // strobes
    always_comb begin
        tel_start = tx_en & ~tx_q & (state == ST_IDLE);
        bit_start = tx_en & bit_fall & ((state == ST_ARMED) | (state == ST_SECOND));
        mid_bit   = tx_en & bit_rise & (state == ST_FIRST);
    end
endmodule

// File: rtl/lce_prbs.sv
`timescale 1ns/1ps
module lce_prbs #(
    parameter int W   = 9,
    parameter int TAP = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    output logic         bit_o
);
    logic [W-1:0] sr;

    assign bit_o = sr[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '1;
        end else if (load) begin
            sr <= (seed == '0) ? '1 : seed;
        end else if (step) begin
            sr <= {sr[W-2:0], sr[W-1] ^ sr[TAP-1]};
        end
    end
endmodule

// File: rtl/lce_raw_cnt.sv
`timescale 1ns/1ps
module lce_raw_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] init,
    output logic         active
);
    logic [W-1:0] cnt;

    assign active = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= init;
        end else if (step && active) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/lce_chip_enc.sv
`timescale 1ns/1ps
module lce_chip_enc
    import lce_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              raw,
    input  logic              at_mid,
    input  logic              data,
    input  logic              lvl,
    output logic              nxt
);
    always_comb begin
        nxt = data;
        if (!raw) begin
            unique case (code)
                CODE_MANCH: nxt = at_mid ? ~data : data;
                CODE_DIFF:  nxt = at_mid ? ~lvl : (lvl ^ ~data);
                CODE_BPS:   nxt = at_mid ? (lvl ^ ~data) : ~lvl;
                CODE_BPM:   nxt = at_mid ? (lvl ^ data) : ~lvl;
                default:    nxt = data;
            endcase
        end
    end
endmodule

// File: rtl/line_code_encoder.sv
`timescale 1ns/1ps
module line_code_encoder
    import lce_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PRBS_W   = 9,
    parameter int PRBS_TAP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              sync_mode,
    input  logic              enc_en,
    input  logic [CODE_W-1:0] code_sel,
    input  logic              invert,
    input  logic [CNT_W-1:0]  raw_bits,
    input  logic              prbs_sel,
    input  logic [PRBS_W-1:0] prbs_seed,
    input  logic              bit_clk,
    input  logic              din,
    output logic              line_out
);
    lce_state_t        state;
    logic              tel_start, bit_start, mid_bit;
    logic              cnt_active, prbs_bit, src_bit, raw_now;
    logic              data_q, raw_q, lvl_q, out_q;
    logic              enc_data, enc_raw, enc_nxt;
    logic [CODE_W-1:0] cfg_code;
    logic              cfg_inv, cfg_enc, cfg_prbs;

    lce_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .bit_clk   (bit_clk),
        .state     (state),
        .tel_start (tel_start),
        .bit_start (bit_start),
        .mid_bit   (mid_bit)
    );

    lce_prbs #(.W(PRBS_W), .TAP(PRBS_TAP)) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tel_start),
        .step  (bit_start & cfg_prbs),
        .seed  (prbs_seed),
        .bit_o (prbs_bit)
    );

    lce_raw_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tel_start),
        .step   (bit_start),
        .init   (raw_bits),
        .active (cnt_active)
    );

    // telegram configuration snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_code <= CODE_MANCH;
            cfg_inv  <= 1'b0;
            cfg_enc  <= 1'b0;
            cfg_prbs <= 1'b0;
        end else if (tel_start) begin
            cfg_code <= code_sel;
            cfg_inv  <= invert;
            cfg_enc  <= enc_en & sync_mode & (code_sel < CODE_LIMIT);
            cfg_prbs <= prbs_sel;
        end
    end

    assign src_bit  = cfg_prbs ? prbs_bit : din;
    assign raw_now  = cnt_active | ~cfg_enc;
    assign enc_data = mid_bit ? data_q : src_bit;
    assign enc_raw  = mid_bit ? raw_q  : raw_now;

    lce_chip_enc u_enc (
        .code   (cfg_code),
        .raw    (enc_raw),
        .at_mid (mid_bit),
        .data   (enc_data),
        .lvl    (lvl_q),
        .nxt    (enc_nxt)
    );

    // per-bit latches and coding level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= 1'b0;
            raw_q  <= 1'b1;
            lvl_q  <= 1'b0;
        end else begin
            if (bit_start) begin
                data_q <= src_bit;
                raw_q  <= raw_now;
            end
            if (tel_start) begin
                lvl_q <= 1'b0;
            end else if (bit_start || mid_bit) begin
                lvl_q <= enc_nxt;
            end
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (!tx_en) begin
            out_q <= 1'b0;
        end else if (tel_start) begin
            out_q <= invert;
        end else if (bit_start || mid_bit) begin
            out_q <= enc_nxt ^ cfg_inv;
        end
    end

    assign line_out = out_q;
endmodule

// File: rtl/lce_checker.sv
`timescale 1ns/1ps
module lce_checker
    import lce_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              line_out,
    input logic              bit_start,
    input logic              mid_bit,
    input logic              raw_now,
    input logic              raw_q,
    input logic              data_q,
    input logic              src_bit,
    input logic [CODE_W-1:0] cfg_code,
    input logic              cfg_inv,
    input lce_state_t        state
);
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !line_out);

    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && tx_en && !bit_start && !mid_bit |=> $stable(line_out));

    p_manch_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start && !raw_now && (cfg_code == CODE_MANCH) |=> line_out == ($past(src_bit) ^ cfg_inv));

    p_manch_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mid_bit && !raw_q && (cfg_code == CODE_MANCH) |=> line_out != $past(line_out));

    p_diff_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mid_bit && !raw_q && (cfg_code == CODE_DIFF) |=> line_out != $past(line_out));

    p_bps_edges_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_start && !raw_now && (cfg_code == CODE_BPS)) ||
        (mid_bit && !raw_q && !data_q && (cfg_code == CODE_BPS)) |=> line_out != $past(line_out));

    p_bpm_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_start && !raw_now && (cfg_code == CODE_BPM)) ||
        (mid_bit && !raw_q && data_q && (cfg_code == CODE_BPM)) |=> line_out != $past(line_out));

    p_nrz_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start && raw_now |=> line_out == ($past(src_bit) ^ cfg_inv));

    p_nrz_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mid_bit && raw_q |=> $stable(line_out));
endmodule

bind line_code_encoder lce_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .line_out  (line_out),
    .bit_start (bit_start),
    .mid_bit   (mid_bit),
    .raw_now   (raw_now),
    .raw_q     (raw_q),
    .data_q    (data_q),
    .src_bit   (src_bit),
    .cfg_code  (cfg_code),
    .cfg_inv   (cfg_inv),
    .state     (state)
);

// File: tb/line_code_encoder_tb_top.sv
`timescale 1ns/1ps
module line_code_encoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, sync_mode = 1'b1, enc_en = 1'b1, invert = 1'b0;
    logic [2:0] code_sel = 3'd0;
    logic [7:0] raw_bits = 8'd0;
    logic       prbs_sel = 1'b0;
    logic [8:0] prbs_seed = 9'd0;
    logic       bit_clk = 1'b1, din = 1'b0;
    logic       line_out;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // scoreboard
    logic  exp_q[$];
    string tag_q[$];
    event  smp;

    // bench model state
    logic       m_lvl;
    int         m_cnt;
    logic [8:0] m_prbs;

    always #4 clk = ~clk;

    line_code_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sync_mode(sync_mode),
        .enc_en(enc_en), .code_sel(code_sel), .invert(invert),
        .raw_bits(raw_bits), .prbs_sel(prbs_sel), .prbs_seed(prbs_seed),
        .bit_clk(bit_clk), .din(din), .line_out(line_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: line_out=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(smp);
            while (exp_q.size() > 0) check(line_out, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // driver: one half bit, expectation pushed after the chip settles
    task automatic drive_half(input logic b, input logic d, input logic e, input string tag);
        @(negedge clk);
        bit_clk = b;
        din = d;
        @(negedge clk);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        ->smp;
    endtask

    task automatic start_tel();
        @(negedge clk);
        tx_en = 1'b0;
        bit_clk = 1'b1;
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        m_lvl = 1'b0;
        m_cnt = int'(raw_bits);
        m_prbs = (prbs_seed == 9'd0) ? 9'h1FF : prbs_seed;
        repeat (2) @(negedge clk);
        check(line_out, invert, "R1 reference level");
    endtask

    task automatic end_tel();
        @(negedge clk);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        check(line_out, 1'b0, "R1 idle after telegram");
    endtask

    task automatic send_bit(input logic d, input string tag);
        logic b, raw, h1, h2;
        b = prbs_sel ? m_prbs[8] : d;
        if (prbs_sel) m_prbs = {m_prbs[7:0], m_prbs[8] ^ m_prbs[4]};
        raw = (m_cnt != 0) || !enc_en || !sync_mode || (code_sel > 3'd3);
        if (m_cnt != 0) m_cnt--;
        if (raw) begin
            h1 = b; h2 = b;
        end else begin
            case (code_sel)
                3'd0:    begin h1 = b;          h2 = ~b;      end
                3'd1:    begin h1 = m_lvl ^ ~b; h2 = ~h1;     end
                3'd2:    begin h1 = ~m_lvl;     h2 = h1 ^ ~b; end
                default: begin h1 = ~m_lvl;     h2 = h1 ^ b;  end
            endcase
        end
        m_lvl = h2;
        drive_half(1'b0, prbs_sel ? ~b : d, h1 ^ invert, tag);
        drive_half(1'b1, prbs_sel ? ~b : d, h2 ^ invert, tag);
    endtask

    task automatic run_bits(input logic [15:0] pat, input int n, input string tag);
        for (int i = 0; i < n; i++) send_bit(pat[i], tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(line_out, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: bit clock and data activity while idle has no effect
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); bit_clk = ~bit_clk; din = ~din;
            @(negedge clk); check(line_out, 1'b0, "R1 idle ignores bit clock");
        end

        // R2 R3: fixed Manchester vectors 1,0 -> chips 1 0 0 1
        code_sel = 3'd0; start_tel();
        drive_half(1'b0, 1'b1, 1'b1, "R2 R3 first half of 1");
        drive_half(1'b1, 1'b1, 1'b0, "R2 R3 second half of 1");
        drive_half(1'b0, 1'b0, 1'b0, "R3 first half of 0");
        drive_half(1'b1, 1'b0, 1'b1, "R3 second half of 0");
        end_tel();

        // R6: fixed bi-phase mark vectors 1,0 -> chips 1 0 1 1
        code_sel = 3'd3; start_tel();
        drive_half(1'b0, 1'b1, 1'b1, "R6 start toggle");
        drive_half(1'b1, 1'b1, 1'b0, "R6 mid toggle on 1");
        drive_half(1'b0, 1'b0, 1'b1, "R6 start toggle");
        drive_half(1'b1, 1'b0, 1'b1, "R6 no mid toggle on 0");
        end_tel();

        // R3..R6 under several patterns
        code_sel = 3'd0; start_tel(); run_bits(16'hB4C9, 12, "R3 Manchester"); end_tel();
        code_sel = 3'd1; start_tel(); run_bits(16'hB4C9, 12, "R4 diff Manchester"); end_tel();
        code_sel = 3'd1; start_tel(); run_bits(16'h0F0F, 10, "R4 diff Manchester runs"); end_tel();
        code_sel = 3'd2; start_tel(); run_bits(16'h3A65, 12, "R5 bi-phase space"); end_tel();
        code_sel = 3'd3; start_tel(); run_bits(16'h3A65, 12, "R6 bi-phase mark"); end_tel();

        // R7: reserved codes and disabled coding give NRZ
        code_sel = 3'd5; start_tel(); run_bits(16'h00D6, 8, "R7 reserved code"); end_tel();
        code_sel = 3'd0; enc_en = 1'b0; start_tel(); run_bits(16'h00D6, 8, "R7 coding off"); end_tel();
        enc_en = 1'b1; sync_mode = 1'b0; start_tel(); run_bits(16'h00D6, 8, "R7 async mode"); end_tel();
        sync_mode = 1'b1;

        // R8: NRZ prefix, reloaded on each telegram
        raw_bits = 8'd3; code_sel = 3'd0;
        start_tel(); run_bits(16'h0A5B, 8, "R8 prefix first telegram"); end_tel();
        start_tel(); run_bits(16'h0A5B, 8, "R8 prefix reload"); end_tel();
        code_sel = 3'd3;
        start_tel(); run_bits(16'h0C35, 8, "R8 level carried into coding"); end_tel();

        // R9: inversion
        invert = 1'b1; raw_bits = 8'd2; code_sel = 3'd2;
        start_tel(); run_bits(16'h0E29, 10, "R9 inverted bi-phase space"); end_tel();
        code_sel = 3'd0; raw_bits = 8'd0;
        start_tel(); run_bits(16'h0E29, 6, "R9 inverted Manchester"); end_tel();
        invert = 1'b0;

        // R10: pseudo-random source replaces din
        prbs_sel = 1'b1; prbs_seed = 9'h1A5; raw_bits = 8'd20; code_sel = 3'd0;
        start_tel(); run_bits(16'h0000, 24, "R10 PRBS sequence"); end_tel();
        start_tel(); run_bits(16'hFFFF, 6, "R10 PRBS reseeded"); end_tel();

        // R11: zero seed replaced by all ones
        prbs_seed = 9'h000; code_sel = 3'd5; raw_bits = 8'd0;
        start_tel(); run_bits(16'h0000, 14, "R11 zero seed"); end_tel();
        prbs_sel = 1'b0;

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule